// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves data between peripheral devices and memory on behalf of four independent channels. Software sets up each channel through a byte-wide register port. It loads a 16-bit start address, a 16-bit count, an 8-bit page that forms the upper memory address bits, and a transfer direction. It then unmasks the channel. A device raises its request line, and the controller answers with one acknowledge cycle. During that cycle it drives the memory address and one memory strobe, then returns to idle. The next unit is granted only in a later cycle, so every transfer is a single-unit bus tenure.

The 16-bit address and count registers are reached one byte at a time through a single byte-pointer flip-flop that all channels share. The flip-flop alternates between the low and the high byte on each access. Only the low 16 address bits count, so a transfer wraps inside its 64 KiB page. The programmed count is one less than the number of units to move. When the count passes below zero, the channel raises a terminal-count flag, pulses a terminal-count output and masks itself.

Register map (5-bit register address):

| Address | Write | Read |
|---|---|---|
| 0x00+ch | current address byte | current address byte |
| 0x04+ch | current count byte | current count byte |
| 0x08+ch | page | page |
| 0x0C | mode | 0 |
| 0x0D | single mask | 0 |
| 0x10 | clear byte pointer | 0 |
| 0x11 | master clear | 0 |
| 0x12 | clear all masks | 0 |
| 0x13 | write all masks | 0 |
| 0x14 | (none) | status |

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, no acknowledge, memory strobe or terminal-count output is active, the status reads 0, and all four channels are masked, so a request gets no acknowledge.
- R2: Accesses to the address port (0x00+ch) and the count port (0x04+ch) go to the low byte and then the high byte, as set by one byte pointer shared by all channels. Reads also toggle the pointer. A write of any value to 0x10 returns the pointer to the low byte.
- R3: A channel programmed with count N performs exactly N+1 units. After it finishes, its count reads 0xFFFF.
- R4: During a transfer, mem_addr[23:16] equals the channel page and mem_addr[15:0] equals the current address. The current address increments by one per unit and wraps from 0xFFFF to 0x0000 without changing the page.
- R5: A mode write to 0x0C selects the channel with bits 1:0 and the direction with bits 3:2. Value 01 (for example 0x44|ch) strobes mem_wr (device to memory). Value 10 (for example 0x48|ch) strobes mem_rd (memory to device). The two strobes are never active together.
- R6: A write to 0x0D with bit 2 set masks the channel given in bits 1:0. The same write with bit 2 clear unmasks that channel.
- R7: A write to 0x11 masks all channels, clears the status and resets the byte pointer. A write to 0x12 unmasks all channels. A write to 0x13 loads the four mask bits from data bits 3:0 (bit n masks channel n).
- R8: A read of 0x14 returns the terminal-count flags in bits 3:0 (bit n for channel n) and clears them. A flag that sets in the same cycle as the read is kept.
- R9: Each grant gives exactly one acknowledge cycle, and the acknowledge is low in the following cycle. At most one acknowledge line is high at a time.
- R10: When several unmasked channels request at once, the lowest-numbered channel is acknowledged first.
- R11: In the last unit's acknowledge cycle, tc is high. Afterwards the channel's status flag is set and the channel is masked.
- R12: A channel that was masked, or was not requesting, in the cycle before is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| dreq | input | 4 | Per-channel device request |
| dack | output | 4 | Per-channel acknowledge |
| mem_addr | output | 24 | Memory address: page in 23:16, address counter in 15:0 |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| tc | output | 1 | Terminal count, high in the last unit's acknowledge cycle |

## Verification
The properties assume that reg_wr and reg_rd each last one cycle per access, and that a request seen in a cycle reflects the device's state in that same cycle. The bench drives every register access as a single-cycle strobe on the falling edge. It raises and drops requests only on falling edges, and it drops a request on the edge where the final acknowledge is seen. The grant checks compare the acknowledge with the request and mask of the cycle before, so the stimulus never relies on a request that appears and vanishes inside one cycle.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int PORT_AW = 5;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        DIR_CHECK    = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_RSVD     = 2'b11
    } xfer_dir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic ld_addr;
        logic ld_cnt;
        logic ld_page;
        logic ld_mode;
    } chan_ld_t;

    localparam logic [PORT_AW-1:0] P_MODE     = 5'h0C;
    localparam logic [PORT_AW-1:0] P_SMASK    = 5'h0D;
    localparam logic [PORT_AW-1:0] P_CLR_PTR  = 5'h10;
    localparam logic [PORT_AW-1:0] P_MCLR     = 5'h11;
    localparam logic [PORT_AW-1:0] P_CLR_MASK = 5'h12;
    localparam logic [PORT_AW-1:0] P_ALL_MASK = 5'h13;
    localparam logic [PORT_AW-1:0] P_STATUS   = 5'h14;

    function automatic logic is_addr_port(input logic [PORT_AW-1:0] a);
        return a[PORT_AW-1:2] == 3'b000;
    endfunction

    function automatic logic is_cnt_port(input logic [PORT_AW-1:0] a);
        return a[PORT_AW-1:2] == 3'b001;
    endfunction

    function automatic logic is_page_port(input logic [PORT_AW-1:0] a);
        return a[PORT_AW-1:2] == 3'b010;
    endfunction

endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CW-1:0]  idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CW'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_ld_t          ld,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic [PAGE_W-1:0] page,
    output xfer_dir_e         dir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            page     <= '0;
            dir      <= DIR_CHECK;
        end else begin
            if (step) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                cur_cnt  <= cur_cnt - ADDR_W'(1);
            end else begin
                if (ld.ld_addr) begin
                    if (hi_byte) cur_addr[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
                    else         cur_addr[7:0]        <= wdata;
                end
                if (ld.ld_cnt) begin
                    if (hi_byte) cur_cnt[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
                    else         cur_cnt[7:0]        <= wdata;
                end
            end
            if (ld.ld_page) page <= wdata[PAGE_W-1:0];
            if (ld.ld_mode) dir  <= xfer_dir_e'(wdata[3:2]);
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> cur_addr == $past(cur_addr) + ADDR_W'(1)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> cur_cnt == $past(cur_cnt) - ADDR_W'(1)); // R3
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && !ld.ld_page) |=> $stable(page)); // R4
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int MA_W = ADDR_W + PAGE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PORT_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    input  logic               reg_wr,
    input  logic               reg_rd,
    output logic [BYTE_W-1:0]  reg_rdata,
    input  logic [NCH-1:0]     dreq,
    output logic [NCH-1:0]     dack,
    output logic [MA_W-1:0]    mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               tc
);
    xfer_state_e        state;
    logic [CH_W-1:0]    gnt;
    logic               ptr_hi;
    logic [NCH-1:0]     mask;
    logic [NCH-1:0]     status;

    chan_ld_t           ld   [NCH];
    logic [NCH-1:0]     step;
    logic [ADDR_W-1:0]  ch_addr [NCH];
    logic [ADDR_W-1:0]  ch_cnt  [NCH];
    logic [PAGE_W-1:0]  ch_page [NCH];
    xfer_dir_e          ch_dir  [NCH];

    logic               req_any;
    logic [CH_W-1:0]    req_idx;
    logic               in_xfer;
    logic               last_unit;
    logic               byte_acc;
    logic               mclr_wr;
    logic               stat_rd;

    assign in_xfer   = (state == ST_XFER);
    assign last_unit = (ch_cnt[gnt] == '0);
    assign byte_acc  = (reg_wr || reg_rd) && (is_addr_port(reg_addr) || is_cnt_port(reg_addr));
    assign mclr_wr   = reg_wr && (reg_addr == P_MCLR);
    assign stat_rd   = reg_rd && (reg_addr == P_STATUS);

    dma4_prio #(.NCH(NCH)) u_prio (
        .req (dreq & ~mask),
        .any (req_any),
        .idx (req_idx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_comb begin
            ld[c].ld_addr = reg_wr && is_addr_port(reg_addr) && (reg_addr[1:0] == CH_W'(c));
            ld[c].ld_cnt  = reg_wr && is_cnt_port(reg_addr)  && (reg_addr[1:0] == CH_W'(c));
            ld[c].ld_page = reg_wr && is_page_port(reg_addr) && (reg_addr[1:0] == CH_W'(c));
            ld[c].ld_mode = reg_wr && (reg_addr == P_MODE)   && (reg_wdata[1:0] == CH_W'(c));
        end
        assign step[c] = in_xfer && (gnt == CH_W'(c));

        dma4_chan #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ld       (ld[c]),
            .hi_byte  (ptr_hi),
            .wdata    (reg_wdata),
            .step     (step[c]),
            .cur_addr (ch_addr[c]),
            .cur_cnt  (ch_cnt[c]),
            .page     (ch_page[c]),
            .dir      (ch_dir[c])
        );
    end

    // Transfer sequencer: one acknowledge cycle per grant, then idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            gnt   <= '0;
        end else if (in_xfer) begin
            state <= ST_IDLE;
        end else if (req_any) begin
            state <= ST_XFER;
            gnt   <= req_idx;
        end
    end

    // Shared byte pointer
    always_ff @(posedge clk) begin
        if (rst) ptr_hi <= 1'b0;
        else if (mclr_wr || (reg_wr && reg_addr == P_CLR_PTR)) ptr_hi <= 1'b0;
        else if (byte_acc) ptr_hi <= ~ptr_hi;
    end

    // Channel masks: software operations first, automatic mask on terminal count
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else begin
            logic [NCH-1:0] m;
            m = mask;
            if (reg_wr) begin
                case (reg_addr)
                    P_MCLR:     m = '1;
                    P_CLR_MASK: m = '0;
                    P_ALL_MASK: m = reg_wdata[NCH-1:0];
                    P_SMASK:    m[reg_wdata[1:0]] = reg_wdata[2];
                    default:    ;
                endcase
            end
            if (tc) m[gnt] = 1'b1;
            mask <= m;
        end
    end

    // Terminal-count flags: read clears, a new flag wins
    always_ff @(posedge clk) begin
        if (rst || mclr_wr) begin
            status <= '0;
        end else begin
            logic [NCH-1:0] s;
            s = stat_rd ? '0 : status;
            if (tc) s[gnt] = 1'b1;
            status <= s;
        end
    end

    // Read data, one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            logic [ADDR_W-1:0] w;
            w = is_addr_port(reg_addr) ? ch_addr[reg_addr[1:0]] : ch_cnt[reg_addr[1:0]];
            if (is_addr_port(reg_addr) || is_cnt_port(reg_addr))
                reg_rdata <= ptr_hi ? BYTE_W'(w[ADDR_W-1:8]) : w[7:0];
            else if (is_page_port(reg_addr))
                reg_rdata <= BYTE_W'(ch_page[reg_addr[1:0]]);
            else if (reg_addr == P_STATUS)
                reg_rdata <= BYTE_W'(status);
            else
                reg_rdata <= '0;
        end
    end

    always_comb begin
        dack     = '0;
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        tc       = 1'b0;
        if (in_xfer) begin
            dack[gnt] = 1'b1;
            mem_addr  = {ch_page[gnt], ch_addr[gnt]};
            mem_wr    = (ch_dir[gnt] == DIR_TO_MEM);
            mem_rd    = (ch_dir[gnt] == DIR_FROM_MEM);
            tc        = last_unit;
        end
    end

    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R9
    AST_SINGLE_UNIT: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |=> (dack == '0)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R5
    AST_NO_MASKED_ACK: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> ((dack & $past(dreq) & ~$past(mask)) != '0)); // R12
    AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> (($past(dreq) & ~$past(mask) & (dack - NCH'(1))) == '0)); // R10
    AST_TC_AUTOMASK: assert property (@(posedge clk) disable iff (rst)
        tc |=> ((mask & $past(dack)) == $past(dack))); // R11
    AST_TC_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tc && !mclr_wr) |=> ((status & $past(dack)) != '0)); // R8
endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic        tc;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dma4_ctrl uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic program_chan(input int ch, input logic [15:0] a, input logic [15:0] n,
                                input logic [7:0] pg, input logic [7:0] mode);
        wr(5'h10, 8'h00);
        wr(5'(ch), a[7:0]);
        wr(5'(ch), a[15:8]);
        wr(5'(4 + ch), n[7:0]);
        wr(5'(4 + ch), n[15:8]);
        wr(5'(8 + ch), pg);
        wr(5'h0C, mode | 8'(ch));
    endtask

    task automatic expect_idle(input logic [3:0] req, input int cycles, input string tag);
        bit seen = 0;
        dreq = req;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (dack != 4'h0) seen = 1;
        end
        dreq = '0;
        chk(!seen, tag, seen, 0);
    endtask

    task automatic run_units(input int ch, input int n, input logic [15:0] base,
                             input logic [7:0] pg, input bit to_mem);
        int got = 0;
        int cyc = 0;
        bit prev = 0;
        dreq[ch] = 1'b1;
        while (got < n && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (prev) chk(dack == 4'h0, "R9 ack gap", dack, 0);
            prev = (dack != 4'h0);
            if (dack != 4'h0) begin
                logic [15:0] ea;
                ea = base + 16'(got);
                chk(dack == 4'(1 << ch), "R12 ack line", dack, 1 << ch);
                chk(mem_addr == {pg, ea}, "R4 mem address", mem_addr, {pg, ea});
                chk(mem_wr == to_mem && mem_rd == !to_mem, "R5 strobe", {mem_rd, mem_wr}, {!to_mem, to_mem});
                chk(tc == (got == n - 1), "R11 tc pulse", tc, got == n - 1);
                got++;
                if (got == n) dreq[ch] = 1'b0;
            end
        end
        dreq[ch] = 1'b0;
        chk(got == n, "R3 unit count", got, n);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(dack == 0 && !mem_rd && !mem_wr && !tc, "R1 idle outputs", {dack, mem_rd, mem_wr, tc}, 0);
        rd(5'h14, d);
        chk(d == 8'h00, "R1 status after reset", d, 0);
        program_chan(0, 16'h0000, 16'h0000, 8'h00, 8'h44);
        expect_idle(4'h1, 8, "R1 reset masks channels");
    endtask

    task automatic t_byte_ptr();
        logic [7:0] d;
        wr(5'h10, 8'h00);
        wr(5'h01, 8'h34);
        wr(5'h01, 8'h12);
        wr(5'h10, 8'h00);
        rd(5'h01, d);
        chk(d == 8'h34, "R2 low byte first", d, 8'h34);
        rd(5'h01, d);
        chk(d == 8'h12, "R2 high byte second", d, 8'h12);
        wr(5'h10, 8'h00);
        wr(5'h01, 8'hAA);
        wr(5'h10, 8'h5A);
        wr(5'h01, 8'h55);
        wr(5'h10, 8'h00);
        rd(5'h01, d);
        chk(d == 8'h55, "R2 clear pointer to low", d, 8'h55);
        rd(5'h01, d);
        chk(d == 8'h12, "R2 high byte kept", d, 8'h12);
    endtask

    task automatic t_wrap_tc();
        logic [7:0] d;
        program_chan(2, 16'hFFFE, 16'h0003, 8'h3C, 8'h44);
        wr(5'h0D, 8'h02);
        run_units(2, 4, 16'hFFFE, 8'h3C, 1'b1);
        expect_idle(4'h4, 8, "R11 auto mask after tc");
        rd(5'h14, d);
        chk(d == 8'h04, "R8 status flag ch2", d, 8'h04);
        rd(5'h14, d);
        chk(d == 8'h00, "R8 status cleared by read", d, 0);
        wr(5'h10, 8'h00);
        rd(5'h02, d);
        chk(d == 8'h02, "R4 wrapped address low", d, 8'h02);
        rd(5'h02, d);
        chk(d == 8'h00, "R4 wrapped address high", d, 8'h00);
        rd(5'h06, d);
        chk(d == 8'hFF, "R3 final count low", d, 8'hFF);
        rd(5'h06, d);
        chk(d == 8'hFF, "R3 final count high", d, 8'hFF);
        rd(5'h0A, d);
        chk(d == 8'h3C, "R4 page unchanged", d, 8'h3C);
    endtask

    task automatic t_read_dir();
        program_chan(3, 16'h0100, 16'h0000, 8'h01, 8'h48);
        wr(5'h0D, 8'h03);
        run_units(3, 1, 16'h0100, 8'h01, 1'b0);
    endtask

    task automatic t_priority();
        int order = 0;
        int cyc = 0;
        program_chan(0, 16'h0200, 16'h0000, 8'h00, 8'h44);
        program_chan(1, 16'h0300, 16'h0000, 8'h00, 8'h44);
        wr(5'h12, 8'h00);
        dreq = 4'h3;
        while (order < 2 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (dack != 0) begin
                if (order == 0) chk(dack == 4'h1, "R10 channel 0 first", dack, 4'h1);
                else            chk(dack == 4'h2, "R10 channel 1 second", dack, 4'h2);
                order++;
            end
        end
        dreq = '0;
        chk(order == 2, "R10 both served", order, 2);
        wr(5'h13, 8'h0F);
    endtask

    task automatic t_single_mask();
        program_chan(0, 16'h0400, 16'h0001, 8'h05, 8'h44);
        wr(5'h0D, 8'h00);
        wr(5'h0D, 8'h04);
        expect_idle(4'h1, 8, "R6 masked by bit 2 set");
        wr(5'h0D, 8'h00);
        run_units(0, 2, 16'h0400, 8'h05, 1'b1);
    endtask

    task automatic t_master();
        logic [7:0] d;
        program_chan(1, 16'h0010, 16'h0000, 8'h00, 8'h44);
        wr(5'h12, 8'h00);
        wr(5'h11, 8'h00);
        expect_idle(4'h2, 8, "R7 master clear masks");
        wr(5'h13, 8'h0D);
        expect_idle(4'h1, 8, "R7 all-mask keeps ch0 masked");
        run_units(1, 1, 16'h0010, 8'h00, 1'b1);
        wr(5'h10, 8'h00);
        wr(5'h03, 8'h77);
        wr(5'h11, 8'h00);
        wr(5'h03, 8'h99);
        wr(5'h10, 8'h00);
        rd(5'h03, d);
        chk(d == 8'h99, "R7 master clear resets pointer", d, 8'h99);
        rd(5'h03, d);
        chk(d == 8'h01, "R7 high byte untouched", d, 8'h01);
        rd(5'h14, d);
        chk(d == 8'h00, "R7 status cleared", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_ptr();
        t_wrap_tc();
        t_read_dir();
        t_priority();
        t_single_mask();
        t_master();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule